// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches one non-maskable interrupt input and a set of external interrupt request lines. Each request line can run in one of two modes. In level mode its flag follows the line and reads 1 while the line is low. In edge mode a falling edge sets the flag, and the flag stays set until software removes it. The block raises a single-cycle NMI request pulse on the chosen NMI edge, and it drives a combined request output that is high while any line flag is set.

Software uses a small register bus with address, write enable, read enable and data lines. That bus reaches two registers. The mode register holds one sense bit for each line and the NMI edge-select bit. The status register holds the line flags with the bit order reversed. A flag held in edge mode is removed only by writing 0 to it after a read has returned 1 for that same flag. This rule keeps software from losing a request that it has not yet seen.

Every external input passes through a two-flop synchronizer first. A power-on reset clears both registers. Raising the standby input stops all detection, but the block keeps its register contents and the bus still works.

Top module: `ext_irq_detect`

## Requirements
- R1: After power-on reset (`por_n` low), the mode register and the status register both read 0, and `nmi_req` and `irq_req` are both low.
- R2: The mode register is at address 0. Bits 8..0 are written by a write and read back unchanged. Bits 15..9 always read 0.
- R3: Mode bit 8 selects the NMI edge. A value of 0 detects a falling edge and 1 detects a rising edge. Each selected edge of `nmi_in` gives exactly one cycle of `nmi_req` high. The opposite edge gives no pulse.
- R4: When mode bit n is 0 (level mode), the flag of line n reads 1 while the synchronized input is low and reads 0 while it is high. Bus writes do not change this flag.
- R5: When mode bit n is 1 (edge mode), a falling edge on line n sets its flag. The flag stays set after the line returns high.
- R6: The status register is at address 1. Line n's flag is at bit 7−n, so line 0 is at bit 7 and line 7 is at bit 0. Bits 15..8 read 0 and writes to them are ignored.
- R7: An edge-mode flag is cleared only by a status write of 0 to its bit after a read has returned 1 for that flag. A write of 0 with no such read leaves the flag set. A write of 1 has no effect. The clearing write also consumes the read.
- R8: If a new edge on a line arrives in the same cycle as a valid clearing write for that line, the flag stays set.
- R9: `irq_req` is high exactly when at least one line flag is set.
- R10: While `standby` is high, no flag changes from line activity and no `nmi_req` pulse is produced. Edges that occur during standby are ignored, and the register contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| standby | input | 1 | High stops detection and keeps the register state |
| nmi_in | input | 1 | Non-maskable interrupt input, asynchronous |
| irq_in | input | 8 | External request lines, asynchronous, idle high |
| addr | input | 2 | Register address: 0 = mode, 1 = status |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle `rd_en` is high, 0 otherwise |
| nmi_req | output | 1 | One-cycle pulse on each selected NMI edge |
| irq_req | output | 1 | OR of all line flags |

## Verification
The hardest case to reach is an edge that sets a flag in the same cycle that a valid clearing write lands on it. The flag must already be set and armed by a read. The line must then return high and fall again. The write must fall exactly in the one cycle where the synchronized sample is low and the previous sample is still high. The stimulus reaches this by counting clock edges after the falling input: the first two edges load the two synchronizer stages, and the clearing write is driven so that it is active through the third edge. A similar counted window is used to show that a write of 0 before any read, and a write of 1, leave the flag set.

// File: rtl/eid_pkg.sv
package eid_pkg;
    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned STAT_ADDR = 1;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_FALL  = 1'b1
    } sense_e;

    typedef enum logic {
        NMI_FALLING = 1'b0,
        NMI_RISING  = 1'b1
    } nmi_edge_e;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    // idle-high inputs: reset to 1 so no spurious edge or level follows reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {3*W{1'b1}};
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/eid_line.sv
module eid_line
    import eid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic mode,
    input  logic cur,
    input  logic prev,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic flag
);
    typedef struct packed {
        logic flag;
        logic armed;
    } line_t;

    line_t st_d, st_q;
    logic  fall, wr_zero, clr;

    assign fall    = prev & ~cur & ~standby;
    assign wr_zero = wr_hit & ~wbit;
    assign clr     = wr_zero & st_q.armed;

    always_comb begin
        st_d = st_q;
        if (sense_e'(mode) == SENSE_LEVEL) begin
            st_d.armed = 1'b0;
            if (!standby) st_d.flag = ~cur;
        end else begin
            if (wr_zero)                   st_d.armed = 1'b0;
            else if (rd_hit && st_q.flag)  st_d.armed = 1'b1;
            if (fall)                      st_d.flag = 1'b1;
            else if (clr)                  st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              standby,
    input  logic              nmi_in,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              nmi_req,
    output logic              irq_req
);
    localparam int unsigned NMI_BIT = N_IRQ;
    localparam int unsigned CTRL_W  = N_IRQ + 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              nmi_pulse;
    } top_t;

    top_t st_d, st_q;

    logic [N_IRQ-1:0] irq_cur, irq_prev, flag_vec, mode_edge;
    logic             nmi_cur, nmi_prev, nmi_edge;
    logic             sel_ctrl, sel_stat, wr_ctrl, rd_stat, wr_stat;
    logic [N_IRQ-1:0] stat_bits;
    logic             unused_wdata;

    assign sel_ctrl = (addr == ADDR_W'(CTRL_ADDR));
    assign sel_stat = (addr == ADDR_W'(STAT_ADDR));
    assign wr_ctrl  = wr_en & sel_ctrl;
    assign wr_stat  = wr_en & sel_stat;
    assign rd_stat  = rd_en & sel_stat;
    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

    eid_sync #(.W(N_IRQ)) u_irq_sync (
        .clk(clk), .rst_n(por_n), .din(irq_in), .cur(irq_cur), .prev(irq_prev)
    );

    eid_sync #(.W(1)) u_nmi_sync (
        .clk(clk), .rst_n(por_n), .din(nmi_in), .cur(nmi_cur), .prev(nmi_prev)
    );

    assign mode_edge = st_q.ctrl[N_IRQ-1:0];

    for (genvar n = 0; n < N_IRQ; n++) begin : g_line
        eid_line u_line (
            .clk(clk), .rst_n(por_n), .standby(standby), .mode(mode_edge[n]),
            .cur(irq_cur[n]), .prev(irq_prev[n]), .rd_hit(rd_stat),
            .wr_hit(wr_stat), .wbit(wdata[N_IRQ-1-n]), .flag(flag_vec[n])
        );
        assign stat_bits[N_IRQ-1-n] = flag_vec[n];
    end

    always_comb begin
        if (nmi_edge_e'(st_q.ctrl[NMI_BIT]) == NMI_RISING)
            nmi_edge = ~nmi_prev & nmi_cur;
        else
            nmi_edge = nmi_prev & ~nmi_cur;
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = wdata[CTRL_W-1:0];
        st_d.nmi_pulse = nmi_edge & ~standby;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_ctrl)      rdata[CTRL_W-1:0] = st_q.ctrl;
            else if (sel_stat) rdata[N_IRQ-1:0]  = stat_bits;
        end
    end

    assign nmi_req = st_q.nmi_pulse;
    assign irq_req = |flag_vec;
endmodule

// File: rtl/eid_checker.sv
module eid_checker
    import eid_pkg::*;
#(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              por_n,
    input logic              standby,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              nmi_req,
    input logic              irq_req,
    input logic [N_IRQ-1:0]  flags,
    input logic [N_IRQ-1:0]  modes
);
    logic             rd_s, rd_c, wr_s;
    logic [N_IRQ-1:0] keep;

    assign rd_s = rd_en && (addr == ADDR_W'(STAT_ADDR));
    assign rd_c = rd_en && (addr == ADDR_W'(CTRL_ADDR));
    assign wr_s = wr_en && (addr == ADDR_W'(STAT_ADDR));

    always_comb begin
        for (int n = 0; n < N_IRQ; n++) keep[n] = modes[n] & wdata[N_IRQ-1-n];
    end

    assert_nmi_one_cycle_R3: assert property (@(posedge clk) disable iff (!por_n)
        nmi_req |=> !nmi_req);

    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
        rd_c |-> (rdata[DATA_W-1:N_IRQ+1] == '0));

    assert_stat_reserved_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
        rd_s |-> (rdata[DATA_W-1:N_IRQ] == '0));

    assert_irq_req_matches_R9: assert property (@(posedge clk) disable iff (!por_n)
        rd_s |-> (irq_req == (rdata[N_IRQ-1:0] != '0)));

    assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!por_n)
        wr_s |=> (($past(flags & keep) & ~flags) == '0));

    assert_standby_holds_R10: assert property (@(posedge clk) disable iff (!por_n)
        (standby && !wr_s) |=> (flags == $past(flags)));

    assert_no_nmi_in_standby_R10: assert property (@(posedge clk) disable iff (!por_n)
        standby |=> !nmi_req);
endmodule

bind ext_irq_detect eid_checker #(.N_IRQ(N_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .por_n(por_n), .standby(standby), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .nmi_req(nmi_req),
    .irq_req(irq_req), .flags(flag_vec), .modes(mode_edge)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        standby = 1'b0;
    logic        nmi_in = 1'b1;
    logic [7:0]  irq_in = 8'hFF;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        nmi_req, irq_req;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;

    always #4 clk = ~clk;

    ext_irq_detect u_dut (
        .clk(clk), .por_n(por_n), .standby(standby), .nmi_in(nmi_in),
        .irq_in(irq_in), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .nmi_req(nmi_req), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // all bus tasks start and end just after a falling clock edge
    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_nmi(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (nmi_req) c++;
        end
    endtask

    task automatic pulse_line(input int n);
        irq_in[n] = 1'b0; wait_cyc(4);
        irq_in[n] = 1'b1; wait_cyc(4);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        bus_read(A_CTRL, d); check("R1 ctrl after reset", d, 16'h0000);
        bus_read(A_STAT, d); check("R1 status after reset", d, 16'h0000);
        check("R1 nmi_req after reset", {15'h0, nmi_req}, 16'h0);
        check("R1 irq_req after reset", {15'h0, irq_req}, 16'h0);
    endtask

    task automatic t_ctrl;
        logic [15:0] d;
        bus_write(A_CTRL, 16'hFFFF);
        bus_read(A_CTRL, d); check("R2 ctrl all ones readback", d, 16'h01FF);
        bus_write(A_CTRL, 16'h0125);
        bus_read(A_CTRL, d); check("R2 ctrl pattern readback", d, 16'h0125);
        bus_write(A_CTRL, 16'h0000);
        bus_read(A_CTRL, d); check("R2 ctrl cleared", d, 16'h0000);
    endtask

    task automatic t_nmi;
        int c;
        nmi_in = 1'b0; count_nmi(6, c); check("R3 falling edge pulse count", 16'(c), 16'd1);
        nmi_in = 1'b1; count_nmi(6, c); check("R3 rising ignored in falling mode", 16'(c), 16'd0);
        bus_write(A_CTRL, 16'h0100);
        nmi_in = 1'b0; count_nmi(6, c); check("R3 falling ignored in rising mode", 16'(c), 16'd0);
        nmi_in = 1'b1; count_nmi(6, c); check("R3 rising edge pulse count", 16'(c), 16'd1);
        bus_write(A_CTRL, 16'h0000);
    endtask

    task automatic t_level;
        logic [15:0] d;
        irq_in[6] = 1'b0; wait_cyc(4);
        bus_read(A_STAT, d); check("R4 level low line 6 at bit 1", d, 16'h0002);
        check("R9 irq_req with level flag", {15'h0, irq_req}, 16'h1);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R4 level flag ignores write 0", d, 16'h0002);
        irq_in[6] = 1'b1; wait_cyc(4);
        bus_read(A_STAT, d); check("R4 level flag drops with line high", d, 16'h0000);
        irq_in[3] = 1'b0; irq_in[5] = 1'b0; wait_cyc(4);
        bus_read(A_STAT, d); check("R6 lines 3 and 5 at bits 4 and 2", d, 16'h0014);
        bus_write(A_STAT, 16'hFF00);
        bus_read(A_STAT, d); check("R6 reserved bits ignore writes", d, 16'h0014);
        irq_in = 8'hFF; wait_cyc(4);
        bus_read(A_STAT, d); check("R9 status empty", d, 16'h0000);
        check("R9 irq_req low with no flag", {15'h0, irq_req}, 16'h0);
    endtask

    task automatic t_edge_clear;
        logic [15:0] d;
        bus_write(A_CTRL, 16'h0001);
        pulse_line(0);
        check("R5 edge flag kept, irq_req", {15'h0, irq_req}, 16'h1);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R7 write 0 without read keeps flag, R5 held", d, 16'h0080);
        bus_write(A_STAT, 16'h00FF);
        bus_read(A_STAT, d); check("R7 write 1 keeps flag", d, 16'h0080);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R7 read then write 0 clears", d, 16'h0000);
        check("R9 irq_req low after clear", {15'h0, irq_req}, 16'h0);
        pulse_line(0);
        bus_read(A_STAT, d); check("R7 flag set again", d, 16'h0080);
        bus_write(A_STAT, 16'h0000);
        pulse_line(0);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R7 clearing write consumed the read", d, 16'h0080);
        bus_write(A_STAT, 16'h0000);
        bus_write(A_CTRL, 16'h0000);
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        bus_write(A_CTRL, 16'h0004);
        pulse_line(2);
        bus_read(A_STAT, d); check("R5 line 2 flag at bit 5", d, 16'h0020);
        irq_in[2] = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        bus_write(A_STAT, 16'h0000);
        irq_in[2] = 1'b1; wait_cyc(4);
        bus_read(A_STAT, d); check("R8 edge during clear keeps flag", d, 16'h0020);
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R8 later clear works", d, 16'h0000);
        bus_write(A_CTRL, 16'h0000);
    endtask

    task automatic t_standby;
        logic [15:0] d;
        int c;
        bus_write(A_CTRL, 16'h0002);
        pulse_line(1);
        bus_write(A_CTRL, 16'h000A);
        standby = 1'b1;
        pulse_line(3);
        nmi_in = 1'b0; count_nmi(6, c);
        check("R10 no nmi pulse in standby", 16'(c), 16'd0);
        nmi_in = 1'b1; wait_cyc(4);
        check("R10 irq_req kept in standby", {15'h0, irq_req}, 16'h1);
        standby = 1'b0; wait_cyc(2);
        bus_read(A_STAT, d); check("R10 flag kept, edge in standby ignored", d, 16'h0040);
        bus_read(A_CTRL, d); check("R10 ctrl kept through standby", d, 16'h000A);
    endtask

    task automatic t_por;
        logic [15:0] d;
        por_n = 1'b0; wait_cyc(2);
        check("R1 irq_req in reset", {15'h0, irq_req}, 16'h0);
        por_n = 1'b1; wait_cyc(2);
        bus_read(A_STAT, d); check("R1 power-on reset clears status", d, 16'h0000);
        bus_read(A_CTRL, d); check("R1 power-on reset clears ctrl", d, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(3);
        por_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_ctrl();
        t_nmi();
        t_level();
        t_edge_clear();
        t_same_cycle();
        t_standby();
        t_por();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule